// File: doc/BRIEF.md
# Multi-Phase Coarse Counter Time Stamper

The block turns an event (a hit) into a time stamp made of two parts: a coarse count of reference clock periods since initialisation and a fine index that a delay-line interpolator reports for the position of the hit inside the reference period. The coarse count is a problem because the hit is not aligned to the reference clock, so a single counter can be caught in the middle of an increment. To avoid this, the block keeps several copies of the coarse counter. Each copy increments at a different phase of the reference period, and all copies are captured on the hit. The top bits of the fine index show which part of the period the hit fell in. From them the block picks the copy whose increment lay half a period away from the hit, which is the copy that was certainly stable, and adds a fixed correction for that copy.

The block runs on a phase clock `clk_i` at `NUM_PH` times the reference rate, so one reference period lasts `NUM_PH` cycles. A 2-bit phase sequencer chooses the copy to increment on each edge. The default is four copies, a 32-bit coarse count and an 8-bit fine index (256 taps span one reference period). The stamp is presented as `{coarse, fine}`. The block also reports the interval between each stamp and the previous one, as their difference.

Top module: `mph_tstamp`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first `fine_vld_i`, `stamp_vld_o` and `ivl_vld_o` are 0 and `stamp_o` is 0.
- R2: The low `FINE_W` bits of a valid stamp equal the `fine_i` value that was sampled together with `fine_vld_i`.
- R3: The edges after reset or init are numbered 0, 1, 2, …, and edge i has phase i mod `NUM_PH`. When the hit is sampled on edge i and the fine index quarter `fine_i[7:6]` equals that phase, the coarse field (`stamp_o[CNT_W+FINE_W-1:FINE_W]`) equals the number of phase-0 edges strictly before edge i, that is floor((i+3)/4), for each of the four phases.
- R4: `stamp_vld_o` is high for exactly one cycle, in the cycle after each cycle in which `fine_vld_i` is sampled high, and is low otherwise.
- R5: An `init_i` pulse clears all counters and the phase together. Edge numbering restarts at 0 on the next edge, and a stamp taken afterwards counts from 0.
- R6: The coarse count wraps silently modulo 2^`CNT_W` and keeps stamping correctly after the wrap.
- R7: `ivl_vld_o` rises with a stamp only when an earlier stamp exists since the last reset or init. `ivl_o` then equals the new stamp minus the previous one, modulo 2^(`CNT_W`+`FINE_W`).
- R8: The capture registers change only on a hit. A second `fine_vld_i` with no new hit yields the same coarse value.
- R9: Copy k increments only on phase-k edges, so every copy is either equal to the next copy or one ahead of it (modulo 2^`CNT_W`). The coarse value is correct whether the fine index arrives one cycle or several cycles after the hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock, `NUM_PH` edges per reference period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous clear of counters and phase |
| hit_i | input | 1 | Event strobe; captures all counter copies |
| fine_i | input | FINE_W | Fine interpolator index; top 2 bits give the quarter |
| fine_vld_i | input | 1 | Fine index valid; produces a stamp |
| stamp_o | output | CNT_W+FINE_W | Time stamp `{coarse, fine}` |
| stamp_vld_o | output | 1 | Stamp valid strobe |
| ivl_o | output | CNT_W+FINE_W | Difference from the previous stamp |
| ivl_vld_o | output | 1 | Interval valid strobe |

## Verification
The hardest cases are a hit whose phase lands on each possible quarter, because the selected copy differs by quarter and only one quarter needs a correction. The other hard case is a coarse count that crosses its wrap. The stimulus tracks the edge number after init so that it can place a hit on a chosen phase and give the matching quarter in the fine index. The bench is built with a narrow coarse width, and long sequences of hits then cross the wrap within a few thousand cycles. The gap from hit to fine index is varied, and fine indices are repeated without a new hit.

// File: rtl/mph_tstamp_pkg.sv
package mph_tstamp_pkg;

  // copy whose increment sits half a period away from the hit quarter
  function automatic int unsigned sel_of(int unsigned qtr, int unsigned n_ph);
    return (qtr + n_ph / 2) % n_ph;
  endfunction

  // copy k lags copy 0 when the hit phase has not yet reached k
  function automatic logic corr_of(int unsigned qtr, int unsigned sel);
    return (qtr != 0) && (qtr <= sel);
  endfunction

endpackage

// File: rtl/mph_tstamp_ctr.sv
module mph_tstamp_ctr #(
  parameter int unsigned NUM_PH = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           init_i,
  output logic [NUM_PH-1:0][CNT_W-1:0]   cnt_o
);
  localparam int unsigned PH_W = $clog2(NUM_PH);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ph_q <= '0;
    else if (init_i)                      ph_q <= '0;
    else if (ph_q == PH_W'(NUM_PH - 1))   ph_q <= '0;
    else                                  ph_q <= ph_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_PH; k++) begin : g_copy
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cnt_q <= '0;
      else if (init_i)             cnt_q <= '0;
      else if (ph_q == PH_W'(k))   cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_o[k] = cnt_q;
  end

endmodule

// File: rtl/mph_tstamp_cap.sv
module mph_tstamp_cap #(
  parameter int unsigned NUM_PH = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           hit_i,
  input  logic [NUM_PH-1:0][CNT_W-1:0]   cnt_i,
  output logic [NUM_PH-1:0][CNT_W-1:0]   cap_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_o <= '0;
    else if (hit_i) cap_o <= cnt_i;
  end

endmodule

// File: rtl/mph_tstamp_sel.sv
module mph_tstamp_sel
  import mph_tstamp_pkg::*;
#(
  parameter int unsigned NUM_PH = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned FINE_W = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            init_i,
  input  logic [NUM_PH-1:0][CNT_W-1:0]    cap_i,
  input  logic [FINE_W-1:0]               fine_i,
  input  logic                            fine_vld_i,
  output logic [CNT_W+FINE_W-1:0]         stamp_o,
  output logic                            stamp_vld_o,
  output logic [CNT_W+FINE_W-1:0]         ivl_o,
  output logic                            ivl_vld_o
);
  localparam int unsigned PH_W    = $clog2(NUM_PH);
  localparam int unsigned STAMP_W = CNT_W + FINE_W;

  logic [PH_W-1:0]    qtr, sel;
  logic               corr;
  logic [CNT_W-1:0]   coarse;
  logic [STAMP_W-1:0] stamp_d;
  logic               have_prev_q;

  assign qtr = fine_i[FINE_W-1 -: PH_W];

  always_comb begin
    sel     = PH_W'(sel_of(32'(qtr), NUM_PH));
    corr    = corr_of(32'(qtr), 32'(sel));
    coarse  = cap_i[sel] + CNT_W'(corr);
    stamp_d = {coarse, fine_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_o     <= '0;
      stamp_vld_o <= 1'b0;
      ivl_o       <= '0;
      ivl_vld_o   <= 1'b0;
      have_prev_q <= 1'b0;
    end else begin
      stamp_vld_o <= fine_vld_i;
      ivl_vld_o   <= fine_vld_i && have_prev_q && !init_i;
      if (fine_vld_i) begin
        stamp_o <= stamp_d;
        ivl_o   <= stamp_d - stamp_o;
      end
      if (init_i)          have_prev_q <= 1'b0;
      else if (fine_vld_i) have_prev_q <= 1'b1;
    end
  end

endmodule

// File: rtl/mph_tstamp.sv
module mph_tstamp #(
  parameter int unsigned NUM_PH = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned FINE_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      init_i,
  input  logic                      hit_i,
  input  logic [FINE_W-1:0]         fine_i,
  input  logic                      fine_vld_i,
  output logic [CNT_W+FINE_W-1:0]   stamp_o,
  output logic                      stamp_vld_o,
  output logic [CNT_W+FINE_W-1:0]   ivl_o,
  output logic                      ivl_vld_o
);

  logic [NUM_PH-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_PH-1:0][CNT_W-1:0] cap_q;

  mph_tstamp_ctr #(.NUM_PH(NUM_PH), .CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_i),
    .cnt_o  (cnt_q)
  );

  mph_tstamp_cap #(.NUM_PH(NUM_PH), .CNT_W(CNT_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit_i),
    .cnt_i  (cnt_q),
    .cap_o  (cap_q)
  );

  mph_tstamp_sel #(.NUM_PH(NUM_PH), .CNT_W(CNT_W), .FINE_W(FINE_W)) u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .cap_i       (cap_q),
    .fine_i      (fine_i),
    .fine_vld_i  (fine_vld_i),
    .stamp_o     (stamp_o),
    .stamp_vld_o (stamp_vld_o),
    .ivl_o       (ivl_o),
    .ivl_vld_o   (ivl_vld_o)
  );

endmodule

// File: rtl/mph_tstamp_chk.sv
module mph_tstamp_chk #(
  parameter int unsigned NUM_PH = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned FINE_W = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          init_i,
  input logic [FINE_W-1:0]             fine_i,
  input logic                          fine_vld_i,
  input logic [CNT_W+FINE_W-1:0]       stamp_i,
  input logic                          stamp_vld_i,
  input logic                          ivl_vld_i,
  input logic [NUM_PH-1:0][CNT_W-1:0]  cnt_i
);

  // R4
  fine_to_stamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_vld_i |=> stamp_vld_i);

  // R4
  no_spurious_stamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fine_vld_i |=> !stamp_vld_i);

  // R2
  fine_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_vld_i |=> (stamp_i[FINE_W-1:0] == $past(fine_i)));

  // R7
  ivl_with_stamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ivl_vld_i |-> stamp_vld_i);

  // R5
  init_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (cnt_i == '0));

  for (genvar k = 0; k < NUM_PH; k++) begin : g_stag
    logic [CNT_W-1:0] lead;
    assign lead = cnt_i[k] - cnt_i[(k + 1) % NUM_PH];
    if (k == NUM_PH - 1) begin : g_last
      // R9
      wrap_stagger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_i[0] - cnt_i[k]) <= CNT_W'(1));
    end else begin : g_mid
      // R9
      stagger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lead <= CNT_W'(1));
    end
  end

endmodule

bind mph_tstamp mph_tstamp_chk #(.NUM_PH(NUM_PH), .CNT_W(CNT_W), .FINE_W(FINE_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_i      (init_i),
  .fine_i      (fine_i),
  .fine_vld_i  (fine_vld_i),
  .stamp_i     (stamp_o),
  .stamp_vld_i (stamp_vld_o),
  .ivl_vld_i   (ivl_vld_o),
  .cnt_i       (cnt_q)
);

// File: tb/mph_tstamp_tb_top.sv
module mph_tstamp_tb_top;
  localparam int NPH = 4;
  localparam int CW  = 8;
  localparam int FW  = 8;
  localparam int SW  = CW + FW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          init = 1'b0;
  logic          hit = 1'b0;
  logic [FW-1:0] fine = '0;
  logic          fine_vld = 1'b0;
  logic [SW-1:0] stamp, ivl;
  logic          stamp_vld, ivl_vld;

  mph_tstamp #(.NUM_PH(NPH), .CNT_W(CW), .FINE_W(FW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .init_i      (init),
    .hit_i       (hit),
    .fine_i      (fine),
    .fine_vld_i  (fine_vld),
    .stamp_o     (stamp),
    .stamp_vld_o (stamp_vld),
    .ivl_o       (ivl),
    .ivl_vld_o   (ivl_vld)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural reference
  int            nxt = 0;
  int            hit_ph = 0;
  bit [CW-1:0]   cap_true = '0;
  bit            exp_vld = 1'b0, exp_ivl_vld = 1'b0, have_prev = 1'b0;
  bit [SW-1:0]   exp_stamp = '0, exp_ivl = '0, prev = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      nxt = 0; exp_vld = 0; exp_ivl_vld = 0; have_prev = 0;
      exp_stamp = '0; cap_true = '0;
    end else begin
      exp_vld = 0; exp_ivl_vld = 0;
      if (fine_vld) begin
        exp_vld = 1;
        exp_stamp = {cap_true, fine};
        if (have_prev) begin
          exp_ivl_vld = 1;
          exp_ivl = exp_stamp - prev;
        end
        prev = exp_stamp;
        have_prev = 1;
      end
      if (hit) begin
        cap_true = CW'((nxt + 3) / 4);
        hit_ph = nxt % NPH;
      end
      if (init) begin nxt = 0; have_prev = 0; end
      else nxt++;
    end
  end

  task automatic check(string r, logic [SW-1:0] act, logic [SW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        check("R1", SW'(stamp_vld), '0);
        check("R1", SW'(ivl_vld), '0);
        check("R1", stamp, '0);
      end else begin
        check("R4", SW'(stamp_vld), SW'(exp_vld));
        check("R7", SW'(ivl_vld), SW'(exp_ivl_vld));
        if (exp_vld) begin
          check(tag, SW'(stamp[SW-1:FW]), SW'(exp_stamp[SW-1:FW]));
          check("R2", SW'(stamp[FW-1:0]), SW'(exp_stamp[FW-1:0]));
        end
        if (exp_ivl_vld) check("R7", ivl, exp_ivl);
      end
    end
  end

  task automatic send_fine(int low);
    fine = FW'({hit_ph[1:0], 6'(low)});
    fine_vld = 1'b1;
    @(negedge clk);
    fine_vld = 1'b0;
  endtask

  task automatic hit_at(int ph, int gap, int low);
    while (nxt % NPH != ph) @(negedge clk);
    hit = 1'b1;
    @(negedge clk);
    hit = 1'b0;
    repeat (gap) @(negedge clk);
    send_fine(low);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);   // R1: still idle after release
    tag = "R3";
    for (int p = 0; p < NPH; p++) hit_at(p, p, 5 + 9 * p);
    tag = "R8";
    repeat (4) @(negedge clk);
    send_fine(33);
    send_fine(60);
    tag = "R9";
    for (int p = 0; p < NPH; p++) hit_at(p, 0, 17 * p);
    for (int p = NPH - 1; p >= 0; p--) hit_at(p, 6, 3 * p + 1);
    tag = "R5";
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    for (int p = 0; p < NPH; p++) hit_at(p, 1, 40 + p);
    tag = "R6";
    for (int i = 0; i < 160; i++) begin
      hit_at(i % NPH, i % 5, (i * 37) % 64);
      repeat (i % 7 + 6) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R4 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule